// File: doc/BRIEF.md
# Six-Output Double-Edge PWM Timer

This block drives six pulse-width modulated outputs from one shared 16-bit period counter. A 16-bit prescaler paces that counter. Each output has its own set-edge and clear-edge match value, so the position and the width of every pulse can be chosen independently. The counter either runs freely, wrapping at a programmable period, or makes a single pass and stops. New period and edge values are written into shadow registers. They take effect at the period boundary, or at once while the counter is stopped.

Protection and system features sit around this core. A trap pin latches a forced level onto all outputs until software releases it. A burst mode gates each active output with an external carrier. Three capture pins record the counter value on a rising edge. A sync output pulses at a programmable count so that other instances can follow. In slave mode the block waits for such a pulse before it counts. The block has a flat register port, with writes on the clock edge and reads that are combinational. It raises one interrupt line built from per-source flags and per-source enables.

Top module: `pwm_timer`

## Requirements
- R1: After reset every output is low, `irq` is low, and the control register (address 0) and the counter register (address 12) read 0.
- R2: While the run bit (control bit 0) is set, the counter advances one step every (prescale+1) clock cycles, where prescale is held at address 1. While the run bit is clear, the counter holds its value.
- R3: In continuous mode (control bit 1 clear), the counter counts 0,1,…,P and then returns to 0, where P is the active period. The period is written at address 2.
- R4: In run-once mode (control bit 1 set), the counter returns to 0 after reaching P, the run bit clears by itself, and the counter then stays at 0.
- R5: Output i is set when the counter reaches its set value (address 16+i) and cleared when the counter reaches its clear value (address 24+i). When both values are equal, the clear wins and the output stays low.
- R6: A period or edge value written while the counter runs does not take effect until the counter next returns to 0.
- R7: The trap pin, after a two-flop synchroniser, latches the trap state. Within three clock cycles of the pin rising, every output equals its bit in the trap-level register at address 4.
- R8: The trap state stays set after the pin falls. It clears only when control bit 4 is written as 1 while the pin is low. The outputs then follow the counter again.
- R9: With burst enabled (control bit 2) and no trap, each output equals its PWM level ANDed with `carrier_in`.
- R10: A rising edge on capture pin k, after two-flop synchronisation, copies the counter value into the capture register (address 9+k). The value taken is the one present two clock cycles after the pin rose.
- R11: `sync_out` is high for exactly the cycle in which the counter first shows the value at address 3.
- R12: The edge flags (address 7) hold the set match of channel i in bit i and the clear match in bit 6+i. The other flags (address 8) hold capture k in bit k, period end in bit 3 and trap entry in bit 4. Writing 1 to a flag clears it. `irq` is high when any flag is set and its enable bit is set; the enables are at address 5 and address 6 with the same bit layout as the flags.
- R13: In slave mode (control bit 3), a running block holds its counter until `sync_in` pulses. The pulse restarts the count at 0, and the count advances on the following steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| trap_in | input | 1 | Asynchronous trap request |
| carrier_in | input | 1 | External carrier for burst mode |
| cap_in | input | 3 | Capture trigger pins |
| sync_in | input | 1 | Start pulse from a master instance |
| sync_out | output | 1 | Delayed start pulse to slave instances |
| pwm_out | output | 6 | PWM outputs |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong counter state shows up within one step. Every output is compared each cycle with its set/clear window, applied to the counter value read back through the register port. A prescaler or period fault therefore changes the readback sequence, and the very next sample catches it. Shadow-loading faults show up as a wrap at the wrong count within the current period. A trap or capture fault shows up within three cycles of the pin changing. Errors in the flag bits show up in the flag registers and on `irq` in the cycle after the event that should have set them.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL    = 5'd0;
    localparam logic [ADDR_W-1:0] A_PRESC   = 5'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 5'd2;
    localparam logic [ADDR_W-1:0] A_SYNC    = 5'd3;
    localparam logic [ADDR_W-1:0] A_TRAPLVL = 5'd4;
    localparam logic [ADDR_W-1:0] A_IEN_M   = 5'd5;
    localparam logic [ADDR_W-1:0] A_IEN_X   = 5'd6;
    localparam logic [ADDR_W-1:0] A_IST_M   = 5'd7;
    localparam logic [ADDR_W-1:0] A_IST_X   = 5'd8;
    localparam logic [ADDR_W-1:0] A_CNT     = 5'd12;
    localparam int A_CAP0  = 9;
    localparam int A_RISE0 = 16;
    localparam int A_FALL0 = 24;

    localparam int TRAP_REL_BIT = 4;

    typedef struct packed {
        logic slave;
        logic burst;
        logic once;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/pwm_sync2.sv
module pwm_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/pwm_base_cnt.sv
module pwm_base_cnt #(
    parameter int CW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          once,
    input  logic          slave,
    input  logic          sync_in,
    input  logic [PW-1:0] presc,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] dly,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output logic          step_d,
    output logic          load_d,
    output logic          wrap_d,
    output logic          stop_d,
    output logic          sync_out
);
    typedef struct packed {
        logic [PW-1:0] pc;
        logic [CW-1:0] cnt;
        logic          armed;
        logic          live;
        logic          sync;
    } st_t;

    st_t st_d, st_q;
    logic go, restart, tick, endp, stop, step;

    always_comb begin
        st_d    = st_q;
        go      = run && (!slave || st_q.armed);
        restart = run && slave && sync_in;
        tick    = go && st_q.live && (st_q.pc == presc);
        endp    = tick && (st_q.cnt == period);
        stop    = endp && once;

        if (!go || !st_q.live) begin
            st_d.pc = '0;
        end else if (tick) begin
            st_d.pc  = '0;
            st_d.cnt = endp ? '0 : st_q.cnt + 1'b1;
        end else begin
            st_d.pc = st_q.pc + 1'b1;
        end

        if (!run || !slave) st_d.armed = 1'b0;
        if (restart) begin
            st_d.pc    = '0;
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end

        st_d.live = go || restart;
        step      = restart || (go && !st_q.live) || (tick && !stop);
        st_d.sync = step && (st_d.cnt == dly);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q    = st_q.cnt;
    assign cnt_d    = st_d.cnt;
    assign step_d   = step;
    assign load_d   = !go || endp || restart;
    assign wrap_d   = endp;
    assign stop_d   = stop;
    assign sync_out = st_q.sync;

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(st_q.cnt));
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        endp |=> (st_q.cnt == '0));
    a_r11_sync_at_delay: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> (st_q.cnt == $past(dly)));
    a_r13_slave_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slave && !st_q.armed && !sync_in) |=> $stable(st_q.cnt));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] rise,
    input  logic [CW-1:0] fall,
    output logic          level,
    output logic          hit_rise,
    output logic          hit_fall
);
    logic lvl_d, lvl_q;

    always_comb begin
        hit_rise = step && (cnt == rise);
        hit_fall = step && (cnt == fall);
        lvl_d    = lvl_q;
        if (hit_fall)      lvl_d = 1'b0;
        else if (hit_rise) lvl_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign level = lvl_q;

    a_r5_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hit_fall |=> !level);
    a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rise && !hit_fall) |=> level);
endmodule

// File: rtl/pwm_capture.sv
module pwm_capture #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] val,
    output logic          ev
);
    typedef struct packed {
        logic          prev;
        logic [CW-1:0] val;
    } st_t;

    st_t  st_d, st_q;
    logic pin_s;

    pwm_sync2 #(.W(1)) u_sync (.clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s));

    always_comb begin
        st_d      = st_q;
        ev        = pin_s && !st_q.prev;
        st_d.prev = pin_s;
        if (ev) st_d.val = cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;

    a_r10_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (val == $past(cnt)));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int NCAP = 3,
    parameter int CW   = 16,
    parameter int PW   = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [((CW > PW) ? CW : PW)-1:0]  wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [((CW > PW) ? CW : PW)-1:0]  rd_data,
    input  logic                              trap_in,
    input  logic                              carrier_in,
    input  logic [NCAP-1:0]                   cap_in,
    input  logic                              sync_in,
    output logic                              sync_out,
    output logic [NCH-1:0]                    pwm_out,
    output logic                              irq
);
    localparam int DW = (CW > PW) ? CW : PW;
    localparam int MF = 2 * NCH;
    localparam int XF = NCAP + 2;

    typedef struct packed {
        ctrl_t                  ctrl;
        logic [PW-1:0]          presc;
        logic [CW-1:0]          per_sh;
        logic [CW-1:0]          per_act;
        logic [CW-1:0]          dly;
        logic [NCH-1:0]         trap_lvl;
        logic [MF-1:0]          ien_m;
        logic [MF-1:0]          ist_m;
        logic [XF-1:0]          ien_x;
        logic [XF-1:0]          ist_x;
        logic [NCH-1:0][CW-1:0] rise_sh;
        logic [NCH-1:0][CW-1:0] rise_act;
        logic [NCH-1:0][CW-1:0] fall_sh;
        logic [NCH-1:0][CW-1:0] fall_act;
        logic                   trap;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [CW-1:0]          cnt_q, cnt_d;
    logic                   step_d, load_d, wrap_d, stop_d;
    logic [NCH-1:0][CW-1:0] rise_act_d, fall_act_d;
    logic [NCH-1:0]         raw, hr, hf;
    logic [NCAP-1:0][CW-1:0] cap_val;
    logic [NCAP-1:0]        cap_ev;
    logic                   trap_s, trap_clr;
    logic [MF-1:0]          clr_m;
    logic [XF-1:0]          clr_x;

    pwm_sync2 #(.W(1)) u_trap_sync (.clk(clk), .rst_n(rst_n), .d(trap_in), .q(trap_s));

    pwm_base_cnt #(.CW(CW), .PW(PW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .run(regs_q.ctrl.run), .once(regs_q.ctrl.once), .slave(regs_q.ctrl.slave),
        .sync_in(sync_in), .presc(regs_q.presc), .period(regs_q.per_act), .dly(regs_q.dly),
        .cnt_q(cnt_q), .cnt_d(cnt_d), .step_d(step_d), .load_d(load_d),
        .wrap_d(wrap_d), .stop_d(stop_d), .sync_out(sync_out)
    );

    always_comb begin
        rise_act_d = load_d ? regs_q.rise_sh : regs_q.rise_act;
        fall_act_d = load_d ? regs_q.fall_sh : regs_q.fall_act;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .step(step_d), .cnt(cnt_d),
            .rise(rise_act_d[i]), .fall(fall_act_d[i]),
            .level(raw[i]), .hit_rise(hr[i]), .hit_fall(hf[i])
        );
    end

    for (genvar k = 0; k < NCAP; k++) begin : g_cap
        pwm_capture #(.CW(CW)) u_cap (
            .clk(clk), .rst_n(rst_n), .pin(cap_in[k]), .cnt(cnt_q),
            .val(cap_val[k]), .ev(cap_ev[k])
        );
    end

    always_comb begin
        regs_d   = regs_q;
        trap_clr = wr_en && (wr_addr == A_CTRL) && wr_data[TRAP_REL_BIT];
        clr_m    = (wr_en && (wr_addr == A_IST_M)) ? wr_data[MF-1:0] : '0;
        clr_x    = (wr_en && (wr_addr == A_IST_X)) ? wr_data[XF-1:0] : '0;

        if (wr_en) begin
            case (wr_addr)
                A_CTRL:    regs_d.ctrl     = wr_data[3:0];
                A_PRESC:   regs_d.presc    = wr_data[PW-1:0];
                A_PERIOD:  regs_d.per_sh   = wr_data[CW-1:0];
                A_SYNC:    regs_d.dly      = wr_data[CW-1:0];
                A_TRAPLVL: regs_d.trap_lvl = wr_data[NCH-1:0];
                A_IEN_M:   regs_d.ien_m    = wr_data[MF-1:0];
                A_IEN_X:   regs_d.ien_x    = wr_data[XF-1:0];
                default: ;
            endcase
        end
        for (int i = 0; i < NCH; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(A_RISE0 + i))) regs_d.rise_sh[i] = wr_data[CW-1:0];
            if (wr_en && (wr_addr == ADDR_W'(A_FALL0 + i))) regs_d.fall_sh[i] = wr_data[CW-1:0];
        end
        if (stop_d) regs_d.ctrl.run = 1'b0;

        regs_d.per_act  = load_d ? regs_q.per_sh : regs_q.per_act;
        regs_d.rise_act = rise_act_d;
        regs_d.fall_act = fall_act_d;

        regs_d.trap  = trap_s || (regs_q.trap && !trap_clr);
        regs_d.ist_m = (regs_q.ist_m & ~clr_m) | {hf, hr};
        regs_d.ist_x = (regs_q.ist_x & ~clr_x) | {regs_d.trap && !regs_q.trap, wrap_d, cap_ev};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:    rd_data[3:0]    = regs_q.ctrl;
            A_PRESC:   rd_data[PW-1:0] = regs_q.presc;
            A_PERIOD:  rd_data[CW-1:0] = regs_q.per_sh;
            A_SYNC:    rd_data[CW-1:0] = regs_q.dly;
            A_TRAPLVL: rd_data[NCH-1:0] = regs_q.trap_lvl;
            A_IEN_M:   rd_data[MF-1:0] = regs_q.ien_m;
            A_IEN_X:   rd_data[XF-1:0] = regs_q.ien_x;
            A_IST_M:   rd_data[MF-1:0] = regs_q.ist_m;
            A_IST_X:   rd_data[XF-1:0] = regs_q.ist_x;
            A_CNT:     rd_data[CW-1:0] = cnt_q;
            default: ;
        endcase
        for (int k = 0; k < NCAP; k++)
            if (rd_addr == ADDR_W'(A_CAP0 + k)) rd_data[CW-1:0] = cap_val[k];
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(A_RISE0 + i)) rd_data[CW-1:0] = regs_q.rise_sh[i];
            if (rd_addr == ADDR_W'(A_FALL0 + i)) rd_data[CW-1:0] = regs_q.fall_sh[i];
        end
    end

    assign pwm_out = regs_q.trap ? regs_q.trap_lvl
                   : (regs_q.ctrl.burst ? (raw & {NCH{carrier_in}}) : raw);
    assign irq = (|(regs_q.ist_m & regs_q.ien_m)) || (|(regs_q.ist_x & regs_q.ien_x));

    a_r4_once_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        stop_d |=> !regs_q.ctrl.run);
    a_r6_shadow_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_d |=> $stable(regs_q.per_act));
    a_r6_shadow_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_d |=> ($stable(regs_q.rise_act) && $stable(regs_q.fall_act)));
    a_r7_trap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        trap_s |=> regs_q.trap);
    a_r8_trap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.trap && !trap_clr) |=> regs_q.trap);
    a_r9_burst_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.trap && regs_q.ctrl.burst && !carrier_in) |-> (pwm_out == '0));
endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;
    localparam int NCH = 6;
    localparam int NCAP = 3;
    localparam int P = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        trap_in = 1'b0;
    logic        carrier_in = 1'b0;
    logic [NCAP-1:0] cap_in = '0;
    logic        sync_in = 1'b0;
    logic        sync_out;
    logic [NCH-1:0] pwm_out;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int RS[NCH] = '{0, 2, 5, 3, 1, 6};
    int FS[NCH] = '{4, 7, 9, 3, 2, 8};

    always #5 clk = ~clk;

    pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .trap_in(trap_in), .carrier_in(carrier_in),
        .cap_in(cap_in), .sync_in(sync_in), .sync_out(sync_out), .pwm_out(pwm_out), .irq(irq)
    );

    function automatic logic [NCH-1:0] expo(input int c);
        logic [NCH-1:0] e;
        for (int i = 0; i < NCH; i++) e[i] = (c >= RS[i]) && (c < FS[i]);
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        int c, prev, v, run_len, mx1, mx2, phase;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 pwm_out", pwm_out, 0);
        chk("R1 irq", irq, 0);
        rd(5'd0, v); chk("R1 ctrl", v, 0);
        rd(5'd12, v); chk("R1 cnt", v, 0);

        // configure edges and period
        wr(5'd2, P);
        for (int i = 0; i < NCH; i++) begin
            wr(5'(16 + i), 16'(RS[i]));
            wr(5'(24 + i), 16'(FS[i]));
        end
        wr(5'd0, 16'h1);
        tick();

        // R3/R5 continuous sweep over three periods
        rd(5'd12, prev);
        for (int n = 0; n < 3 * (P + 1); n++) begin
            rd(5'd12, c);
            chk("R5 window", pwm_out, expo(c));
            tick();
            rd(5'd12, v);
            chk("R3 sequence", v, (c == P) ? 0 : c + 1);
        end

        // R2 prescale: every step lasts presc+1 cycles
        wr(5'd1, 16'd2);
        rd(5'd12, prev);
        run_len = 0; phase = 0;
        for (int n = 0; n < 40; n++) begin
            tick();
            rd(5'd12, c);
            run_len++;
            if (c != prev) begin
                if (phase > 0) chk("R2 step length", run_len, 3);
                phase++;
                run_len = 0;
                prev = c;
            end
        end
        wr(5'd0, 16'h0);
        rd(5'd12, prev);
        repeat (6) tick();
        rd(5'd12, c);
        chk("R2 hold when stopped", c, prev);
        wr(5'd1, 16'd0);

        // R4 run-once
        wr(5'd0, 16'h3);
        repeat (30) tick();
        rd(5'd0, v); chk("R4 run bit cleared", v, 2);
        rd(5'd12, v); chk("R4 counter at zero", v, 0);
        chk("R4 outputs low", pwm_out, 0);
        wr(5'd7, 16'hFFFF);
        wr(5'd8, 16'hFFFF);
        wr(5'd0, 16'h3);
        repeat (20) tick();
        rd(5'd12, v); chk("R4 stays at zero", v, 0);
        rd(5'd7, v); chk("R12 all edge flags", v, 16'hFFF);
        rd(5'd8, v); chk("R12 overflow flag", v & 8, 8);
        chk("R12 irq off when disabled", irq, 0);
        wr(5'd6, 16'h8);
        chk("R12 irq on", irq, 1);
        wr(5'd8, 16'h8);
        chk("R12 irq cleared by w1c", irq, 0);
        wr(5'd6, 16'h0);

        // R6 shadow period load
        wr(5'd0, 16'h1);
        for (int n = 0; n < 50; n++) begin
            rd(5'd12, c);
            if (c == 3) break;
            tick();
        end
        wr(5'd2, 16'd5);
        rd(5'd12, prev);
        mx1 = prev; mx2 = 0; phase = 0;
        for (int n = 0; n < 20; n++) begin
            tick();
            rd(5'd12, c);
            if (c < prev) phase++;
            if (phase == 0 && c > mx1) mx1 = c;
            if (phase == 1 && c > mx2) mx2 = c;
            prev = c;
        end
        chk("R6 old period finishes", mx1, P);
        chk("R6 new period after wrap", mx2, 5);
        wr(5'd2, P);
        repeat (35) tick();

        // R7/R8 trap
        wr(5'd4, 16'h2A);
        trap_in = 1'b1;
        repeat (3) tick();
        chk("R7 trap level", pwm_out, 6'h2A);
        rd(5'd8, v); chk("R12 trap flag", (v >> 4) & 1, 1);
        trap_in = 1'b0;
        repeat (6) tick();
        chk("R8 trap latched", pwm_out, 6'h2A);
        wr(5'd0, 16'h11);
        for (int n = 0; n < P + 1; n++) begin
            rd(5'd12, c);
            chk("R8 released", pwm_out, expo(c));
            tick();
        end

        // R9 burst
        wr(5'd0, 16'h5);
        for (int n = 0; n < 24; n++) begin
            carrier_in = ((n / 3) % 2 == 1) ^ (n % 5 == 0);
            rd(5'd12, c);
            chk("R9 burst gate", pwm_out, expo(c) & {NCH{carrier_in}});
            tick();
        end
        carrier_in = 1'b0;
        wr(5'd0, 16'h1);

        // R10 capture
        for (int k = 0; k < NCAP; k++) begin
            repeat (k + 2) tick();
            cap_in[k] = 1'b1;
            tick();
            tick();
            rd(5'd12, c);
            tick();
            rd(5'(9 + k), v);
            chk("R10 captured count", v, c);
            cap_in[k] = 1'b0;
        end
        rd(5'd8, v); chk("R12 capture flags", v & 7, 7);

        // R11 sync delay
        wr(5'd3, 16'd4);
        tick();
        for (int n = 0; n < 25; n++) begin
            rd(5'd12, c);
            chk("R11 sync pulse", sync_out, (c == 4));
            tick();
        end

        // R13 slave start
        wr(5'd0, 16'h0);
        rd(5'd12, prev);
        wr(5'd0, 16'h9);
        repeat (5) tick();
        rd(5'd12, c); chk("R13 slave waits", c, prev);
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        rd(5'd12, c); chk("R13 restart at zero", c, 0);
        tick();
        rd(5'd12, c); chk("R13 counting after sync", c, 1);

        finish_run();
    end
endmodule